// File: doc/BRIEF.md
# Nonvolatile Store Busy Sequencer

This block times the internal programming cycle that follows a store into a nonvolatile data register. The serial bus engine hands it a store request once the last byte of a store command is accepted. The request carries a channel mask, a register slot and one data lane per channel. The request is only held pending at that point. Programming starts when the STOP condition that closes the transaction arrives, and only if the write-protect input is high at that moment. A repeated START or a missing acknowledge reported before STOP throws the pending store away.

While programming runs, `busy_o` is high. The bus engine uses it to withhold every acknowledge, including the one for the slave address, so a host can poll for completion by sending START plus the address until it is acknowledged. A parameterised cycle count stands in for the programming time, defaulting to 10 ms at a 200 MHz clock. When the count ends, a one-cycle commit strobe presents the mask, slot and data to the register array. A single-register write or a single wiper-to-register transfer uses a one-hot mask. A global transfer uses an all-ones mask and programs every channel in one cycle.

Top module: `nvw_busy_ctrl`

## Requirements
- R1: After reset, `busy_o` and `commit_valid_o` are low and `commit_mask_o` is zero.
- R2: A store request alone does not raise `busy_o`. A `bus_stop_i` pulse while a store is pending, `wp_n_i` is high and the block is idle raises `busy_o` in the next cycle.
- R3: Once raised, `busy_o` stays high for exactly `WRITE_CYCLES` consecutive cycles.
- R4: `commit_valid_o` is high for one cycle only, namely the first cycle in which `busy_o` is low again. In that cycle `commit_mask_o` and `commit_slot_o` equal the latched request. Data lane i (bits i*DW up to i*DW+DW-1) equals the latched lane where mask bit i is 1 and reads zero where it is 0.
- R5: If `wp_n_i` is low at the STOP, no busy period starts and no commit occurs. The pending store is discarded, so a later STOP with `wp_n_i` high starts nothing.
- R6: A `bus_abort_i` pulse before STOP discards the pending store, and the following STOP starts nothing.
- R7: A STOP with no pending store starts nothing.
- R8: Store requests and STOP pulses that arrive while `busy_o` is high are ignored. The busy period keeps its length and the commit carries the original request.
- R9: A store with an all-ones mask commits every channel's lane in a single commit strobe.
- R10: A second store request before STOP replaces the first one, and only the second is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_req_i | input | 1 | Store command accepted by the bus engine (one-cycle pulse) |
| st_mask_i | input | NCHAN | Channels to program; bit i selects channel i |
| st_slot_i | input | SLW | Data register slot to program |
| st_data_i | input | NCHAN*DW | One data lane per channel, lane i at bits i*DW upward |
| bus_abort_i | input | 1 | Repeated START or missing acknowledge before STOP |
| bus_stop_i | input | 1 | STOP condition detected (one-cycle pulse) |
| wp_n_i | input | 1 | Write-protect; low blocks programming |
| busy_o | output | 1 | Programming in progress; the bus engine withholds all acknowledges |
| commit_valid_o | output | 1 | One-cycle strobe that updates the register array |
| commit_mask_o | output | NCHAN | Channels updated by the strobe |
| commit_slot_o | output | SLW | Slot updated by the strobe |
| commit_data_o | output | NCHAN*DW | Lanes to write; unselected lanes are zero |

## Verification
The checker follows every cycle. It checks that a rise of `busy_o` is always preceded by a STOP seen with `wp_n_i` high, and that a STOP seen with protection active while idle leaves `busy_o` low. It counts each busy period against `WRITE_CYCLES` and ties every commit strobe to the falling edge of `busy_o`. Whether the right request was latched is beyond the checker. The same holds for whether an abort, a replacement or a request during busy was discarded. Only the bench's scenarios can show these, by comparing the committed mask, slot and lanes, and by showing that a later STOP starts nothing.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
   typedef enum logic {
      TMR_IDLE = 1'b0,
      TMR_RUN  = 1'b1
   } nvw_tmr_e;

   function automatic int unsigned nvw_cw(input int unsigned cycles);
      return (cycles > 2) ? $clog2(cycles) : 1;
   endfunction
endpackage

// File: rtl/nvw_pending.sv
module nvw_pending #(
   parameter int unsigned NCHAN = 4,
   parameter int unsigned SLW   = 2,
   parameter int unsigned DW    = 6
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  load_i,
   input  logic                  drop_i,
   input  logic [NCHAN-1:0]      mask_i,
   input  logic [SLW-1:0]        slot_i,
   input  logic [NCHAN*DW-1:0]   data_i,
   output logic                  pend_o,
   output logic [NCHAN-1:0]      mask_o,
   output logic [SLW-1:0]        slot_o,
   output logic [NCHAN*DW-1:0]   data_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_o <= 1'b0;
         mask_o <= '0;
         slot_o <= '0;
         data_o <= '0;
      end else if (drop_i) begin
         pend_o <= 1'b0;
      end else if (load_i) begin
         pend_o <= 1'b1;
         mask_o <= mask_i;
         slot_o <= slot_i;
         data_o <= data_i;
      end
   end
endmodule

// File: rtl/nvw_timer.sv
module nvw_timer
   import nvw_pkg::*;
#(
   parameter int unsigned WRITE_CYCLES = 2000000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic run_o,
   output logic done_o
);
   localparam int unsigned CW = nvw_cw(WRITE_CYCLES);

   nvw_tmr_e state_q;

   assign run_o = (state_q == TMR_RUN);

   generate
      if (WRITE_CYCLES == 1) begin : g_single
         assign done_o = run_o;
      end else begin : g_count
         localparam logic [CW-1:0] LAST = CW'(WRITE_CYCLES - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)      cnt_q <= '0;
            else if (!run_o)  cnt_q <= '0;
            else              cnt_q <= cnt_q + 1'b1;
         end
         assign done_o = run_o && (cnt_q == LAST);
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     state_q <= TMR_IDLE;
      else if (start_i && !run_o)      state_q <= TMR_RUN;
      else if (done_o)                 state_q <= TMR_IDLE;
   end
endmodule

// File: rtl/nvw_commit.sv
module nvw_commit #(
   parameter int unsigned NCHAN = 4,
   parameter int unsigned SLW   = 2,
   parameter int unsigned DW    = 6
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  fire_i,
   input  logic [NCHAN-1:0]      mask_i,
   input  logic [SLW-1:0]        slot_i,
   input  logic [NCHAN*DW-1:0]   data_i,
   output logic                  valid_o,
   output logic [NCHAN-1:0]      mask_o,
   output logic [SLW-1:0]        slot_o,
   output logic [NCHAN*DW-1:0]   data_o
);
   logic [NCHAN*DW-1:0] lanes;

   generate
      for (genvar ch = 0; ch < NCHAN; ch++) begin : g_lane
         assign lanes[ch*DW +: DW] = mask_i[ch] ? data_i[ch*DW +: DW] : '0;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_o <= 1'b0;
         mask_o  <= '0;
         slot_o  <= '0;
         data_o  <= '0;
      end else if (fire_i) begin
         valid_o <= 1'b1;
         mask_o  <= mask_i;
         slot_o  <= slot_i;
         data_o  <= lanes;
      end else begin
         valid_o <= 1'b0;
         mask_o  <= '0;
         slot_o  <= '0;
         data_o  <= '0;
      end
   end
endmodule

// File: rtl/nvw_busy_ctrl.sv
module nvw_busy_ctrl #(
   parameter int unsigned NCHAN        = 4,
   parameter int unsigned NSLOT        = 4,
   parameter int unsigned DW           = 6,
   parameter int unsigned WRITE_CYCLES = 2000000,
   localparam int unsigned SLW         = (NSLOT > 1) ? $clog2(NSLOT) : 1,
   localparam int unsigned LW          = NCHAN * DW
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             st_req_i,
   input  logic [NCHAN-1:0] st_mask_i,
   input  logic [SLW-1:0]   st_slot_i,
   input  logic [LW-1:0]    st_data_i,
   input  logic             bus_abort_i,
   input  logic             bus_stop_i,
   input  logic             wp_n_i,
   output logic             busy_o,
   output logic             commit_valid_o,
   output logic [NCHAN-1:0] commit_mask_o,
   output logic [SLW-1:0]   commit_slot_o,
   output logic [LW-1:0]    commit_data_o
);
   generate
      if (NCHAN < 1) begin : g_bad_nchan
         initial $fatal(1, "nvw_busy_ctrl: NCHAN must be at least 1");
      end
      if (DW < 1) begin : g_bad_dw
         initial $fatal(1, "nvw_busy_ctrl: DW must be at least 1");
      end
      if (WRITE_CYCLES < 1) begin : g_bad_cycles
         initial $fatal(1, "nvw_busy_ctrl: WRITE_CYCLES must be at least 1");
      end
   endgenerate

   logic             pend;
   logic [NCHAN-1:0] pend_mask;
   logic [SLW-1:0]   pend_slot;
   logic [LW-1:0]    pend_data;
   logic             running;
   logic             done;
   logic             launch;

   nvw_pending #(.NCHAN(NCHAN), .SLW(SLW), .DW(DW)) u_pend (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (st_req_i && !running),
      .drop_i (bus_stop_i || bus_abort_i),
      .mask_i (st_mask_i),
      .slot_i (st_slot_i),
      .data_i (st_data_i),
      .pend_o (pend),
      .mask_o (pend_mask),
      .slot_o (pend_slot),
      .data_o (pend_data)
   );

   assign launch = bus_stop_i && pend && wp_n_i && !running;

   nvw_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (launch),
      .run_o   (running),
      .done_o  (done)
   );

   nvw_commit #(.NCHAN(NCHAN), .SLW(SLW), .DW(DW)) u_cmt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fire_i  (done),
      .mask_i  (pend_mask),
      .slot_i  (pend_slot),
      .data_i  (pend_data),
      .valid_o (commit_valid_o),
      .mask_o  (commit_mask_o),
      .slot_o  (commit_slot_o),
      .data_o  (commit_data_o)
   );

   assign busy_o = running;
endmodule

// File: rtl/nvw_busy_chk.sv
module nvw_busy_chk #(
   parameter int unsigned WRITE_CYCLES = 2000000
) (
   input logic clk_i,
   input logic rst_ni,
   input logic bus_stop_i,
   input logic wp_n_i,
   input logic busy_o,
   input logic commit_valid_o
);
   logic [31:0] run_len_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      run_len_q <= '0;
      else if (busy_o)  run_len_q <= run_len_q + 32'd1;
      else              run_len_q <= '0;
   end

   // R2
   busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> $past(bus_stop_i && wp_n_i));

   // R5
   wp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_stop_i && !wp_n_i && !busy_o) |=> !busy_o);

   // R3
   busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> (run_len_q == 32'(WRITE_CYCLES)));

   // R3
   busy_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> (run_len_q < 32'(WRITE_CYCLES)));

   // R4
   commit_at_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> commit_valid_o);

   // R4
   commit_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit_valid_o |-> (!busy_o && $past(busy_o)));

   // R4
   commit_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit_valid_o |=> !commit_valid_o);
endmodule

bind nvw_busy_ctrl nvw_busy_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .bus_stop_i     (bus_stop_i),
   .wp_n_i         (wp_n_i),
   .busy_o         (busy_o),
   .commit_valid_o (commit_valid_o)
);

// File: tb/sim_nvw_busy_ctrl.sv
module sim_nvw_busy_ctrl;
   localparam int unsigned NCHAN = 4;
   localparam int unsigned NSLOT = 4;
   localparam int unsigned DW    = 6;
   localparam int unsigned WCYC  = 37;
   localparam int unsigned SLW   = 2;
   localparam int unsigned LW    = NCHAN * DW;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             st_req = 1'b0;
   logic [NCHAN-1:0] st_mask = '0;
   logic [SLW-1:0]   st_slot = '0;
   logic [LW-1:0]    st_data = '0;
   logic             abort_p = 1'b0;
   logic             stop_p = 1'b0;
   logic             wp_n = 1'b1;
   logic             busy;
   logic             cv;
   logic [NCHAN-1:0] cmask;
   logic [SLW-1:0]   cslot;
   logic [LW-1:0]    cdata;

   int compared = 0;
   int mismatched = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   nvw_busy_ctrl #(.NCHAN(NCHAN), .NSLOT(NSLOT), .DW(DW), .WRITE_CYCLES(WCYC)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .st_req_i(st_req), .st_mask_i(st_mask),
      .st_slot_i(st_slot), .st_data_i(st_data), .bus_abort_i(abort_p),
      .bus_stop_i(stop_p), .wp_n_i(wp_n), .busy_o(busy), .commit_valid_o(cv),
      .commit_mask_o(cmask), .commit_slot_o(cslot), .commit_data_o(cdata)
   );

   function automatic logic [LW-1:0] exp_lanes(input logic [NCHAN-1:0] m, input logic [LW-1:0] d);
      logic [LW-1:0] r = '0;
      for (int i = 0; i < NCHAN; i++) if (m[i]) r[i*DW +: DW] = d[i*DW +: DW];
      return r;
   endfunction

   function automatic bit exp_launch(input bit pending, input bit wp_high);
      return pending && wp_high;
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic pulse_stop(input logic wp);
      wp_n = wp; stop_p = 1'b1;
      @(negedge clk);
      stop_p = 1'b0;
   endtask

   task automatic send_req(input logic [NCHAN-1:0] m, input logic [SLW-1:0] s, input logic [LW-1:0] d);
      st_req = 1'b1; st_mask = m; st_slot = s; st_data = d;
      @(negedge clk);
      st_req = 1'b0;
   endtask

   task automatic run_store(input logic [NCHAN-1:0] m, input logic [SLW-1:0] s, input logic [LW-1:0] d,
                            input bit wp, input bit do_abort, input bit do_replace, input bit spur);
      bit go;
      bit quiet;
      int n;
      if (do_replace) send_req(~m, s + 1'b1, ~d);  // R10 older request
      send_req(m, s, d);
      if (do_abort) begin
         abort_p = 1'b1; @(negedge clk); abort_p = 1'b0;
      end
      check(!busy, "R2", 64'(busy), 64'd0);
      pulse_stop(wp);
      go = exp_launch(!do_abort, wp);
      if (!go) begin
         quiet = 1'b1;
         for (int k = 0; k < 4; k++) begin
            if (busy || cv) quiet = 1'b0;
            @(negedge clk);
         end
         check(quiet, do_abort ? "R6" : "R5", 64'(busy), 64'd0);
         pulse_stop(1'b1);
         quiet = 1'b1;
         for (int k = 0; k < 4; k++) begin
            if (busy || cv) quiet = 1'b0;
            @(negedge clk);
         end
         check(quiet, do_abort ? "R6 discard" : "R5 discard", 64'(busy), 64'd0);
         return;
      end
      check(busy == 1'b1, "R2", 64'(busy), 64'd1);
      n = 1;
      while (busy && n < 1000) begin
         if (spur && n == 3) begin
            st_req = 1'b1; st_mask = ~m; st_data = ~d; stop_p = 1'b1;  // R8
         end
         @(negedge clk);
         st_req = 1'b0; stop_p = 1'b0;
         if (busy) n++;
      end
      check(n == WCYC, "R3", 64'(n), 64'(WCYC));
      check(cv == 1'b1, "R4 strobe", 64'(cv), 64'd1);
      check(cmask == m, (m == '1) ? "R9 mask" : (spur ? "R8 mask" : "R4 mask"), 64'(cmask), 64'(m));
      check(cslot == s, do_replace ? "R10 slot" : "R4 slot", 64'(cslot), 64'(s));
      check(cdata == exp_lanes(m, d), (m == '1) ? "R9 data" : "R4 data",
            64'(cdata), 64'(exp_lanes(m, d)));
      @(negedge clk);
      check(cv == 1'b0, "R4 one cycle", 64'(cv), 64'd0);
      if (spur) begin
         pulse_stop(1'b1);
         check(!busy, "R8 ignored", 64'(busy), 64'd0);
      end
   endtask

   always @(posedge clk) cycles++;

   initial begin
      logic [NCHAN-1:0] m;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check(!busy && !cv && cmask == '0, "R1", {62'd0, busy, cv}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !cv, "R1", {62'd0, busy, cv}, 64'd0);
      pulse_stop(1'b1);
      check(!busy, "R7", 64'(busy), 64'd0);
      run_store(4'b0010, 2'd1, 24'h3A5C71, 1'b1, 1'b0, 1'b0, 1'b0);
      run_store(4'b1111, 2'd3, 24'hFEDCBA, 1'b1, 1'b0, 1'b0, 1'b0);
      run_store(4'b0001, 2'd0, 24'h00003F, 1'b0, 1'b0, 1'b0, 1'b0);
      run_store(4'b1000, 2'd2, 24'h123456, 1'b1, 1'b1, 1'b0, 1'b0);
      run_store(4'b0100, 2'd2, 24'h0F0F0F, 1'b1, 1'b0, 1'b1, 1'b0);
      run_store(4'b0001, 2'd1, 24'h2A2A2A, 1'b1, 1'b0, 1'b0, 1'b1);
      for (int it = 0; it < 40; it++) begin
         m = ($urandom % 4 == 0) ? '1 : 4'(1 << ($urandom % NCHAN));
         run_store(m, 2'($urandom), 24'($urandom), ($urandom % 4) != 0,
                   ($urandom % 6) == 0, ($urandom % 5) == 0, ($urandom % 5) == 0);
         repeat ($urandom % 3) @(negedge clk);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule